// File: doc/BRIEF.md
# Precision-gated pipelined unsigned multiplier

The block is a deeply pipelined unsigned multiplier whose precision is chosen externally. A quasi-static setting says how many low-order bits of each operand carry data. Only the registers that can hold a nonzero value at that precision are enabled. Every other register holds its reset value of zero. The enables act both along the pipeline and across each stage, and the result is read from an earlier stage when the precision is lower, so latency falls along with switching activity.

The pipeline starts with an operand capture stage. It is followed by one stage per operand bit index k. Stage k adds the L-shaped layer of partial products whose larger operand index is exactly k. After stage k the running sum is the complete product of the (k+1)-bit operands.

Every register belongs to one precision level: the highest operand bit index it depends on. This covers the operand bits forwarded down the pipe and the running sums alike. Level k runs only when its enable line is set. A change of the setting flushes the pipe with a synchronous clear, and a valid flag reports when results for the new setting start to arrive. Clock gating is modelled as register enables.

Top module: `prec_gated_mult`

## Requirements
- R1: While rst_ni is low, and on the first clock after its release, valid_o is 0 and product_o is 0.
- R2: level_en_i is a thermometer code: precision p means bits 0..p-1 are 1 and all others are 0. With p = 0, valid_o stays 0 and product_o stays 0.
- R3: While valid_o is 1, product_o equals (a mod 2^p) * (b mod 2^p) for the operands sampled p+1 rising edges earlier.
- R4: Operand bits at index p and above are ignored. Setting them does not change product_o.
- R5: Latency is p+1 cycles. Operands driven before rising edge E appear on product_o after rising edge E+p, for every p from 1 to WIDTH.
- R6: Bits of product_o at index 2p and above are always 0 while precision p is in force.
- R7: A change of level_en_i clears the pipe at the next rising edge F. From edge F, valid_o is 0 and product_o is 0. valid_o rises after edge F+1+p, and the first valid product belongs to the operands sampled at edge F+1.
- R8: Driving level_en_i with its current value causes no flush. valid_o stays 1, and results continue without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| level_en_i | input | WIDTH | One enable per precision level, thermometer coded |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| product_o | output | 2*WIDTH | Product read from the tap for the selected precision |
| valid_o | output | 1 | Product is valid for the selected precision |

## Verification
The bench drives operands with bits set above the selected precision. A design that gated the wrong register group would fold those bits into the product or leave stale high result bits. At every precision the bench checks the exact cycle in which valid_o rises after a flush. A tap taken one stage off in either direction shows up as a valid flag one cycle early or late, or as a partial sum presented as final. Switching between full and minimum precision catches a flush that fails to clear: stale nonzero data would appear before the first valid result. Re-driving an unchanged setting catches a design that flushes on every write and drops valid_o.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  function automatic int unsigned ones_count(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += 32'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/pgm_input_reg.sv
module pgm_input_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] en_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] x_o,
  output logic [WIDTH-1:0] y_o
);
  // each operand bit belongs to the level of its own index
  for (genvar j = 0; j < WIDTH; j++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        x_o[j] <= 1'b0;
        y_o[j] <= 1'b0;
      end else if (clr_i) begin
        x_o[j] <= 1'b0;
        y_o[j] <= 1'b0;
      end else if (en_i[j]) begin
        x_o[j] <= a_i[j];
        y_o[j] <= b_i[j];
      end
    end

    p_in_held_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[j] |-> (x_o[j] == 1'b0 && y_o[j] == 1'b0));
  end
endmodule

// File: rtl/pgm_layer_stage.sv
module pgm_layer_stage #(
  parameter int WIDTH = 4,
  parameter int K     = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic [WIDTH-1:0]   en_i,
  input  logic [WIDTH-1:0]   x_i,
  input  logic [WIDTH-1:0]   y_i,
  input  logic [2*WIDTH-1:0] acc_i,
  output logic [WIDTH-1:0]   x_o,
  output logic [WIDTH-1:0]   y_o,
  output logic [2*WIDTH-1:0] acc_o
);
  localparam int PW = 2 * WIDTH;
  localparam int AW = 2 * K + 2;  // width of a (K+1)-bit square product

  logic [PW-1:0] row_x, row_y, sum;
  logic [AW-1:0] acc_q;

  // layer K: x[K]*y[K:0] and y[K]*x[K-1:0], both weighted by 2^K
  assign row_x = x_i[K] ? (PW'(y_i[K:0]) << K) : '0;
  if (K > 0) begin : g_row_y
    assign row_y = y_i[K] ? (PW'(x_i[K-1:0]) << K) : '0;
  end else begin : g_row_y0
    assign row_y = '0;
  end
  assign sum = acc_i + row_x + row_y;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        acc_q <= '0;
    else if (clr_i)     acc_q <= '0;
    else if (en_i[K])   acc_q <= sum[AW-1:0];
  end
  assign acc_o = PW'(acc_q);

  if (AW < PW) begin : g_fit
    p_sum_fits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i[K] |-> (sum[PW-1:AW] == '0));
  end

  if (K < WIDTH - 1) begin : g_fwd
    for (genvar j = 0; j < WIDTH; j++) begin : g_bit
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          x_o[j] <= 1'b0;
          y_o[j] <= 1'b0;
        end else if (clr_i) begin
          x_o[j] <= 1'b0;
          y_o[j] <= 1'b0;
        end else if (en_i[j]) begin
          x_o[j] <= x_i[j];
          y_o[j] <= y_i[j];
        end
      end
    end
  end else begin : g_last
    assign x_o = '0;
    assign y_o = '0;
    p_level_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i[K] |-> (&en_i));
  end

  p_held_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i[K] |-> (acc_q == '0));
endmodule

// File: rtl/pgm_flush_ctrl.sv
module pgm_flush_ctrl #(
  parameter int WIDTH = 4,
  localparam int PRW  = $clog2(WIDTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] en_i,
  output logic [WIDTH-1:0] en_q_o,
  output logic             clr_o,
  output logic [PRW-1:0]   prec_o,
  output logic             valid_o
);
  import pgm_pkg::*;

  logic [WIDTH-1:0] en_q;
  logic [WIDTH:0]   fill_q;  // bit i set: i+1 clean cycles since flush

  assign clr_o = (en_i != en_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      fill_q <= '0;
    end else begin
      en_q <= en_i;
      if (clr_o) fill_q <= '0;
      else       fill_q <= {fill_q[WIDTH-1:0], 1'b1};
    end
  end

  assign en_q_o  = en_q;
  assign prec_o  = PRW'(ones_count(32'(en_q)));
  assign valid_o = (prec_o != '0) && fill_q[prec_o];

  p_flush_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i != en_q) |=> !valid_o);

  p_valid_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && en_i == en_q) |=> valid_o);
endmodule

// File: rtl/prec_gated_mult.sv
module prec_gated_mult #(
  parameter int WIDTH = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [WIDTH-1:0]   level_en_i,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  output logic [2*WIDTH-1:0] product_o,
  output logic               valid_o
);
  localparam int PW  = 2 * WIDTH;
  localparam int PRW = $clog2(WIDTH + 1);

  logic [WIDTH-1:0] en_q;
  logic             clr;
  logic [PRW-1:0]   prec;

  logic [WIDTH-1:0] x_w   [WIDTH];
  logic [WIDTH-1:0] y_w   [WIDTH];
  logic [PW-1:0]    acc_w [WIDTH];

  pgm_flush_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (level_en_i),
    .en_q_o  (en_q),
    .clr_o   (clr),
    .prec_o  (prec),
    .valid_o (valid_o)
  );

  pgm_input_reg #(.WIDTH(WIDTH)) u_in (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .en_i   (en_q),
    .a_i    (a_i),
    .b_i    (b_i),
    .x_o    (x_w[0]),
    .y_o    (y_w[0])
  );

  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    logic [WIDTH-1:0] x_fwd, y_fwd;
    logic [PW-1:0]    acc_in;

    if (k == 0) begin : g_first
      assign acc_in = '0;
    end else begin : g_next
      assign acc_in = acc_w[k-1];
    end

    pgm_layer_stage #(.WIDTH(WIDTH), .K(k)) u_layer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .en_i   (en_q),
      .x_i    (x_w[k]),
      .y_i    (y_w[k]),
      .acc_i  (acc_in),
      .x_o    (x_fwd),
      .y_o    (y_fwd),
      .acc_o  (acc_w[k])
    );

    if (k < WIDTH - 1) begin : g_link
      assign x_w[k+1] = x_fwd;
      assign y_w[k+1] = y_fwd;
    end
  end

  // output tap: stage p-1 holds the finished 2p-bit product
  always_comb begin
    product_o = '0;
    for (int k = 0; k < WIDTH; k++) begin
      if (prec == PRW'(k + 1)) product_o = acc_w[k];
    end
  end

  p_therm_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_en_i & (level_en_i + 1'b1)) == '0);

  p_high_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (product_o >> (2 * prec)) == '0);
endmodule

// File: tb/sim_prec_gated_mult.sv
module sim_prec_gated_mult;
  localparam int W          = 4;
  localparam int CLK_PERIOD = 10;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [W-1:0]   level_en_i = '0;
  logic [W-1:0]   a_i = '0;
  logic [W-1:0]   b_i = '0;
  logic [2*W-1:0] product_o;
  logic           valid_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int flush_cyc = 0;
  int cur_p  = 0;
  bit finished = 1'b0;
  logic [2*W-1:0] exp_ring [64];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  prec_gated_mult #(.WIDTH(W)) u0 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .level_en_i (level_en_i),
    .a_i        (a_i),
    .b_i        (b_i),
    .product_o  (product_o),
    .valid_o    (valid_o)
  );

  task automatic step();
    @(negedge clk_i);
    cyc++;
  endtask

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  task automatic set_prec(int p);
    logic [W-1:0] en;
    en = W'((1 << p) - 1);
    if (en != level_en_i) flush_cyc = cyc;  // flush at the next rising edge
    level_en_i = en;
    cur_p = p;
  endtask

  // mode 0 random, 1 all ones, 2 alternating, 3 top bit of precision only
  task automatic drive(int mode);
    logic [W-1:0] a, b, m;
    case (mode)
      0: begin a = W'($urandom); b = W'($urandom); end
      1: begin a = '1; b = '1; end
      2: begin a = W'(32'h5555_5555 >> (cyc & 1)); b = ~a; end
      default: begin
        a = (cur_p > 0) ? W'(1 << (cur_p - 1)) : '0;
        b = (cur_p > 0) ? W'(1 << (cur_p - 1)) : '0;
        a = a | ~W'((1 << cur_p) - 1);  // junk above the precision
      end
    endcase
    m = W'((1 << cur_p) - 1);
    a_i = a;
    b_i = b;
    exp_ring[cyc % 64] = (2*W)'(a & m) * (2*W)'(b & m);
  endtask

  task automatic check_out(string req);
    bit ev;
    ev = (cur_p > 0) && (cyc >= flush_cyc + 2 + cur_p);
    chk({req, " R5 R7 valid timing"}, longint'(valid_o), longint'(ev));
    if (ev)
      chk({req, " R3 R4 product"}, longint'(product_o), longint'(exp_ring[(cyc - cur_p - 1) % 64]));
    else
      chk({req, " R2 R7 product cleared"}, longint'(product_o), 0);
    chk("R6 upper bits zero", longint'(product_o >> (2 * cur_p)), 0);
  endtask

  task automatic run(int p, int n, int mode, string req);
    set_prec(p);
    drive(mode);
    for (int i = 0; i < n; i++) begin
      step();
      check_out(req);
      drive(mode);
    end
  endtask

  task automatic t_reset();
    step();
    chk("R1 valid in reset", longint'(valid_o), 0);
    chk("R1 product in reset", longint'(product_o), 0);
    rst_ni = 1'b1;
    step();
    chk("R1 valid after release", longint'(valid_o), 0);
    chk("R1 product after release", longint'(product_o), 0);
  endtask

  task automatic t_each_precision();
    for (int p = 1; p <= W; p++) begin
      run(p, 20, 0, "R4 random");
      run(p, 1, 0, "R8 same setting");
      run(p, 12, 3, "R4 junk above");
    end
  endtask

  task automatic t_corners();
    run(W, 10, 1, "R3 full ones");
    run(1, 8, 1, "R7 full to one");
    run(W, 10, 2, "R7 one to full");
    run(W, 10, 2, "R8 rewrite full");
    run(2, 10, 1, "R3 half ones");
    run(0, 8, 0, "R2 idle");
    run(3, 12, 0, "R7 from idle");
  endtask

  initial begin
    t_reset();
    t_each_precision();
    t_corners();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule